// File: doc/BRIEF.md
# Operating-Point Transition Controller

This block moves a core between discrete operating points, where each point is a 16-bit code standing for a frequency and voltage pair. Software programs a requested point through a small register port. The block then hands that code to an external frequency/voltage sequencer over a valid/ready channel. When the sequencer accepts the code, the block records it as the point now in effect. The block does not interpret the code.

The requested point and the live point are held apart. The request register always returns what software last wrote. The live register changes only when the sequencer accepts a code. A new request may be written while a transition is in flight. The in-flight code is left alone, and the newest request is launched once the current transition finishes. Each transition is one direct step to the requested code, with no intermediate codes.

A global enable gates the launching of transitions. A read-only capability register advertises that the mechanism exists.

Register map (2-bit address):
- Address 0: request register; bits [15:0] are read/write.
- Address 1: live register, read-only; bits [15:0] hold the live point and bit 16 is the busy flag.
- Address 2: enable register; only bit 16 is stored.
- Address 3: capability register, read-only; it reads 0x0000_0080.

Back-pressure rules on the sequencer channel:
- `seq_valid` rises with `seq_code` holding the request.
- Both hold unchanged until `seq_ready` is sampled high at a rising edge, which is the accepting edge.
- `seq_ready` may be high at any time; the block has no combinational path from `seq_ready` to `seq_valid`.

Top module: `pstate_ctrl`

## Requirements
- R1: After reset, the following hold:
  - The request register and the live register both read RESET_POINT (default 0x0004).
  - The enable register reads 0.
  - `seq_valid`, `busy` and `xfer_done` are 0.
- R2: A write to address 0 stores `reg_wdata[15:0]`. Reading address 0 returns the last value written, whatever the live point is.
- R3: The enable register keeps only bit 16 of a write, and all its other bits read 0. While that bit is 0, no transition is launched and the live point does not change.
- R4: When the block is enabled, idle (`seq_valid` = 0) and the request differs from the live point, `seq_valid` goes high one clock edge later, with `seq_code` equal to the request.
- R5: While `seq_valid` = 1 and `seq_ready` = 0, `seq_valid` stays 1 and `seq_code` stays unchanged.
- R6: On the accepting edge:
  - The live point (`cur_point` and address 1 bits [15:0]) takes `seq_code` on that same edge.
  - `seq_valid` falls.
  - `xfer_done` is 1 for exactly the following cycle.
- R7: Requests written during a transition do not disturb the in-flight code. Only the last of them is kept, and it is launched on the edge after the accepting edge.
- R8: A request equal to the live point launches no transition.
- R9: Address 3 reads 0x0000_0080 (bit 7 set). Writes to address 3 and to address 1 change no register.
- R10: `busy` and address 1 bit 16 both equal `seq_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| seq_valid | output | 1 | Code offered to the sequencer |
| seq_code | output | 16 | Operating-point code offered |
| seq_ready | input | 1 | Sequencer accepts the offered code |
| cur_point | output | 16 | Live operating point |
| busy | output | 1 | Transition in flight |
| xfer_done | output | 1 | One-cycle pulse after the live point changes |

## Verification
Let edge k be the edge that takes a request write. Then `seq_valid` and `seq_code` are due after edge k+1. The live point changes on the accepting edge, and `xfer_done` is high in the cycle after that edge. A retarget launches on the edge after acceptance.

The bench drives inputs and samples outputs at falling edges, so each check lands in the cycle its result is due. It sweeps many codes against sequencer acceptance delays of 0 to 3 cycles. Expected live points are tracked arithmetically, including codes that happen to equal the live point.

// File: rtl/pstate_pkg.sv
package pstate_pkg;
  typedef enum logic [1:0] {
    SEL_REQUEST = 2'd0,
    SEL_LIVE    = 2'd1,
    SEL_ENABLE  = 2'd2,
    SEL_CAP     = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pstate_regfile.sv
module pstate_regfile import pstate_pkg::*; #(
  parameter int CODE_W      = 16,
  parameter int DATA_W      = 32,
  parameter int EN_BIT      = 16,
  parameter logic [CODE_W-1:0] RESET_POINT = 16'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CODE_W-1:0] request,
  output logic              enable
);
  logic unused_wbits;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      request <= RESET_POINT;
      enable  <= 1'b0;
    end else if (wr) begin
      case (reg_sel_e'(addr))
        SEL_REQUEST: request <= wdata[CODE_W-1:0];
        SEL_ENABLE:  enable  <= wdata[EN_BIT];
        default: ;
      endcase
    end
  end

  assert_request_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == SEL_REQUEST) |=> request == $past(wdata[CODE_W-1:0]));
endmodule

// File: rtl/pstate_launcher.sv
module pstate_launcher #(
  parameter int CODE_W = 16,
  parameter logic [CODE_W-1:0] RESET_POINT = 16'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CODE_W-1:0] request,
  input  logic              seq_ready,
  output logic              seq_valid,
  output logic [CODE_W-1:0] seq_code,
  output logic [CODE_W-1:0] live,
  output logic              done
);
  logic accept;
  logic launch;

  assign accept = seq_valid && seq_ready;
  assign launch = !seq_valid && enable && (request != live);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_valid <= 1'b0;
      seq_code  <= RESET_POINT;
      live      <= RESET_POINT;
      done      <= 1'b0;
    end else begin
      done <= accept;
      if (accept) begin
        live      <= seq_code;
        seq_valid <= 1'b0;
      end else if (launch) begin
        seq_valid <= 1'b1;
        seq_code  <= request;
      end
    end
  end

  assert_no_launch_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !seq_valid) |=> !seq_valid);

  assert_launch_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_valid) |-> seq_code == $past(request));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_valid && !seq_ready) |=> (seq_valid && $stable(seq_code)));

  assert_live_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live) |-> (done && !seq_valid));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/pstate_readmux.sv
module pstate_readmux import pstate_pkg::*; #(
  parameter int CODE_W   = 16,
  parameter int DATA_W   = 32,
  parameter int EN_BIT   = 16,
  parameter int CAP_BIT  = 7,
  parameter int BUSY_BIT = 16
) (
  input  logic [1:0]        addr,
  input  logic [CODE_W-1:0] request,
  input  logic [CODE_W-1:0] live,
  input  logic              enable,
  input  logic              busy,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    case (reg_sel_e'(addr))
      SEL_REQUEST: rdata[CODE_W-1:0] = request;
      SEL_LIVE: begin
        rdata[CODE_W-1:0] = live;
        rdata[BUSY_BIT]   = busy;
      end
      SEL_ENABLE: rdata[EN_BIT]  = enable;
      SEL_CAP:    rdata[CAP_BIT] = 1'b1;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pstate_ctrl.sv
module pstate_ctrl import pstate_pkg::*; #(
  parameter int CODE_W  = 16,
  parameter int DATA_W  = 32,
  parameter int EN_BIT  = 16,
  parameter int CAP_BIT = 7,
  parameter logic [CODE_W-1:0] RESET_POINT = 16'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              seq_valid,
  output logic [CODE_W-1:0] seq_code,
  input  logic              seq_ready,
  output logic [CODE_W-1:0] cur_point,
  output logic              busy,
  output logic              xfer_done
);
  localparam int BUSY_BIT = CODE_W;

  logic [CODE_W-1:0] request;
  logic              enable;

  pstate_regfile #(
    .CODE_W(CODE_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT), .RESET_POINT(RESET_POINT)
  ) u_regfile (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .request(request), .enable(enable)
  );

  pstate_launcher #(
    .CODE_W(CODE_W), .RESET_POINT(RESET_POINT)
  ) u_launcher (
    .clk(clk), .rst_n(rst_n), .enable(enable), .request(request),
    .seq_ready(seq_ready), .seq_valid(seq_valid), .seq_code(seq_code),
    .live(cur_point), .done(xfer_done)
  );

  assign busy = seq_valid;

  pstate_readmux #(
    .CODE_W(CODE_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT),
    .CAP_BIT(CAP_BIT), .BUSY_BIT(BUSY_BIT)
  ) u_readmux (
    .addr(reg_addr), .request(request), .live(cur_point), .enable(enable),
    .busy(busy), .rdata(reg_rdata)
  );

  assert_busy_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == SEL_LIVE) |-> (reg_rdata[BUSY_BIT] == seq_valid));

  assert_live_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == SEL_LIVE) |-> (reg_rdata[CODE_W-1:0] == cur_point));
endmodule

// File: tb/test_pstate_ctrl.sv
module test_pstate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RST_PT = 16'h0004;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic seq_valid;
  logic [15:0] seq_code;
  logic seq_ready = 1'b0;
  logic [15:0] cur_point;
  logic busy;
  logic xfer_done;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [15:0] exp_live = RST_PT;

  always #(CLK_PERIOD/2) clk = ~clk;

  pstate_ctrl i_pstate_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_valid(seq_valid),
    .seq_code(seq_code), .seq_ready(seq_ready), .cur_point(cur_point),
    .busy(busy), .xfer_done(xfer_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic transition(input logic [15:0] code, input int lat);
    logic [31:0] r;
    wr(2'd0, {16'h0, code});
    if (code == exp_live) begin
      repeat (3) begin
        @(negedge clk);
        check("R8 no launch on equal code", {31'b0, seq_valid}, 32'd0);
      end
      check("R8 live unchanged", {16'h0, cur_point}, {16'h0, exp_live});
    end else begin
      @(negedge clk);
      check("R4 valid after launch", {31'b0, seq_valid}, 32'd1);
      check("R4 code", {16'h0, seq_code}, {16'h0, code});
      rd(2'd1, r);
      check("R10 busy bit", {31'b0, r[16]}, 32'd1);
      check("R10 busy port", {31'b0, busy}, 32'd1);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        check("R5 held valid", {31'b0, seq_valid}, 32'd1);
        check("R5 held code", {16'h0, seq_code}, {16'h0, code});
        check("R6 live not yet", {16'h0, cur_point}, {16'h0, exp_live});
      end
      seq_ready = 1'b1;
      @(negedge clk);
      seq_ready = 1'b0;
      check("R6 live updated", {16'h0, cur_point}, {16'h0, code});
      check("R6 done pulse", {31'b0, xfer_done}, 32'd1);
      check("R6 valid drop", {31'b0, seq_valid}, 32'd0);
      exp_live = code;
      @(negedge clk);
      check("R6 done one cycle", {31'b0, xfer_done}, 32'd0);
    end
    rd(2'd0, r);
    check("R2 request readback", r, {16'h0, code});
  endtask

  initial begin
    repeat (CLK_PERIOD * 100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] a, b, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, r); check("R1 request reset", r, {16'h0, RST_PT});
    rd(2'd1, r); check("R1 live reset", r, {16'h0, RST_PT});
    rd(2'd2, r); check("R1 enable reset", r, 32'd0);
    check("R1 valid reset", {31'b0, seq_valid}, 32'd0);
    check("R1 done reset", {31'b0, xfer_done}, 32'd0);
    // R9 capability and read-only registers
    rd(2'd3, r); check("R9 capability", r, 32'h0000_0080);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, r); check("R9 capability write ignored", r, 32'h0000_0080);
    wr(2'd1, 32'h0001_ABCD);
    rd(2'd1, r); check("R9 live write ignored", r, {16'h0, RST_PT});
    // R3 disabled: request stored, no launch
    wr(2'd0, 32'h0000_0011);
    repeat (4) begin
      @(negedge clk);
      check("R3 no launch while disabled", {31'b0, seq_valid}, 32'd0);
    end
    check("R3 live kept", {16'h0, cur_point}, {16'h0, RST_PT});
    rd(2'd0, r); check("R2 request stored while disabled", r, 32'h0000_0011);
    // R3 enable bit mask, then pending request launches
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, r); check("R3 enable mask", r, 32'h0001_0000);
    @(negedge clk);
    check("R4 launch on enable", {31'b0, seq_valid}, 32'd1);
    check("R4 code on enable", {16'h0, seq_code}, 32'h0000_0011);
    seq_ready = 1'b1;
    @(negedge clk);
    seq_ready = 1'b0;
    check("R6 live after enable", {16'h0, cur_point}, 32'h0000_0011);
    exp_live = 16'h0011;
    @(negedge clk);
    // Sweep codes against acceptance delays
    for (int k = 0; k < 48; k++) begin
      logic [15:0] code;
      code = 16'((k * 40503 + 7) & 16'hFFFF);
      if (k % 8 == 5) code = exp_live; // R8 equal-code case
      transition(code, k % 4);
    end
    // R7 retarget during a transition
    a = exp_live ^ 16'h0F0F; b = exp_live ^ 16'h3333; c = exp_live ^ 16'h5A5A;
    wr(2'd0, {16'h0, a});
    @(negedge clk);
    check("R4 launch A", {16'h0, seq_code}, {16'h0, a});
    wr(2'd0, {16'h0, b});
    wr(2'd0, {16'h0, c});
    check("R7 in-flight code kept", {16'h0, seq_code}, {16'h0, a});
    rd(2'd0, r); check("R7 last request kept", r, {16'h0, c});
    seq_ready = 1'b1;
    @(negedge clk);
    check("R7 first completes A", {16'h0, cur_point}, {16'h0, a});
    @(negedge clk);
    check("R7 relaunch valid", {31'b0, seq_valid}, 32'd1);
    check("R7 relaunch code C", {16'h0, seq_code}, {16'h0, c});
    @(negedge clk);
    seq_ready = 1'b0;
    check("R7 live reaches C", {16'h0, cur_point}, {16'h0, c});
    check("R6 done for C", {31'b0, xfer_done}, 32'd1);
    exp_live = c;
    @(negedge clk);
    // R3 disable while idle
    wr(2'd2, 32'd0);
    wr(2'd0, {16'h0, ~exp_live});
    repeat (4) begin
      @(negedge clk);
      check("R3 no launch after disable", {31'b0, seq_valid}, 32'd0);
    end
    check("R3 live kept after disable", {16'h0, cur_point}, {16'h0, exp_live});
    wr(2'd2, 32'h0001_0000);
    @(negedge clk);
    check("R4 launch on re-enable", {16'h0, seq_code}, {16'h0, ~exp_live});
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule